// File: doc/BRIEF.md
# Modem Handshake Control and Status with Diagnostic Loop-Back

This block sits beside one serial channel and owns its modem handshake lines. A small control register, written through a strobe-and-address port, drives four active-low handshake outputs: terminal ready, request to send and two general-purpose outputs. Four active-low handshake inputs are resynchronised to the core clock: clear to send, data set ready, ring and carrier detect. Their current levels can be read from a status register. The same register holds sticky change flags, and an interrupt request stays raised while any flag is set.

A control bit selects a diagnostic loop-back. In that mode the block isolates the external pins. Transmit data from the data path returns as receive data. Each handshake output feeds back into a handshake input: request to send into clear to send, terminal ready into data set ready, the first general output into ring, and the second into carrier detect. Change detection and the interrupt request keep working on these looped levels. Software can therefore exercise the whole status path without any external wiring.

Top module: `mdm_ctl_loop`

## Requirements
- R1: After reset the control register reads 0, all four handshake output pins are 1, the status register reads 0x00 and `msi_req_o` is 0.
- R2: The control register (reg_sel = 0) stores write-data bits 4..0 and reads them back with bits 7..5 as 0. Outside loop-back, bit 0 drives `pin_dtr_n_o`, bit 1 drives `pin_rts_n_o`, bit 2 drives `pin_op1_n_o` and bit 3 drives `pin_op2_n_o`. In each case a 1 in the bit gives a 0 on the pin.
- R3: When control bit 4 is 0, `pin_tx_o` follows `ser_tx_i` and `ser_rx_o` follows `pin_rx_i`.
- R4: When control bit 4 is 1, `pin_tx_o` and all four handshake output pins are 1, and `ser_rx_o` follows `ser_tx_i`.
- R5: Status register (reg_sel = 1) bits 4, 5, 6 and 7 read the complement of the clear-to-send, data-set-ready, ring and carrier-detect pin levels. A pin change becomes visible on the third rising clock edge after it: two synchroniser stages and one level register.
- R6: Status bits 0, 1 and 3 are set by any change of clear to send, data set ready and carrier detect, on the same edge that the new level becomes visible.
- R7: Status bit 2 is set only when the ring pin level goes from 0 to 1. A 1-to-0 change leaves it clear.
- R8: In loop-back, status bits 4, 5, 6 and 7 follow control bits 1, 0, 2 and 3 one edge after the control register changes, and the external input pins have no effect.
- R9: A read strobe on the status register clears bits 3..0 at that edge. A change detected on the same edge still sets its bit.
- R10: `msi_req_o` is 1 exactly when any of status bits 3..0 is 1.
- R11: A set change bit stays set until a status read, however long that is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a status read clears the change bits) |
| reg_sel_i | input | 1 | 0 = control register, 1 = status register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| ser_tx_i | input | 1 | Serial transmit data from the data path |
| ser_rx_o | output | 1 | Serial receive data to the data path |
| pin_tx_o | output | 1 | Transmit pin |
| pin_rx_i | input | 1 | Receive pin |
| pin_cts_n_i | input | 1 | Clear to send, active low |
| pin_dsr_n_i | input | 1 | Data set ready, active low |
| pin_ri_n_i | input | 1 | Ring indicator, active low |
| pin_cd_n_i | input | 1 | Carrier detect, active low |
| pin_dtr_n_o | output | 1 | Terminal ready, active low |
| pin_rts_n_o | output | 1 | Request to send, active low |
| pin_op1_n_o | output | 1 | General output 1, active low |
| pin_op2_n_o | output | 1 | General output 2, active low |
| msi_req_o | output | 1 | Modem-status interrupt request |

## Verification
Two things can land on the same clock edge: a status read that clears the change bits, and the arrival of a new change. The bench sets this up in loop-back. It first leaves a data-set-ready change pending. It then writes request to send so that the looped change is detected on exactly the edge that carries the status read strobe. The read data must still show the old flags. Afterwards, the new clear-to-send flag must survive while the older flag is gone. Outside this collision, sweeps over input-pin patterns and control values compare every status value with levels and edges computed in the bench.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int REG_W = 8;
    localparam int MIN_N = 4;
    localparam int IX_CTS = 0;
    localparam int IX_DSR = 1;
    localparam int IX_RI  = 2;
    localparam int IX_CD  = 3;

    typedef struct packed {
        logic loop_en;
        logic aux2;
        logic aux1;
        logic req_send;
        logic term_rdy;
    } mctl_t;

    localparam int CTL_W = $bits(mctl_t);

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } regsel_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wdata_i,
    output mctl_t            ctl_o
);
    mctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i) ctl_d = mctl_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/mdm_stat.sv
module mdm_stat #(
    parameter int N     = 4,
    parameter int RI_IX = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,   // pin-level (active-low) view of inputs
    input  logic         clr_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] dlt_o
);
    typedef struct packed {
        logic [N-1:0] lvl;
        logic [N-1:0] dlt;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_edge
        if (i == RI_IX) begin : g_trail
            assign hit[i] = lvl_i[i] & ~st_q.lvl[i];
        end else begin : g_any
            assign hit[i] = lvl_i[i] ^ st_q.lvl[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        st_d.dlt = clr_i ? hit : (st_q.dlt | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= '1;
            st_q.dlt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
    assign dlt_o = st_q.dlt;

    // R7: ring flag only appears together with a 0->1 step of the ring level
    p_ri_trailing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dlt[RI_IX]) |-> $rose(st_q.lvl[RI_IX]));

    // R11: without a clearing read no set flag drops
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.dlt & $past(st_q.dlt)) == $past(st_q.dlt)));

    // R9: a read with no concurrent change leaves every flag clear
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (lvl_i == st_q.lvl)) |=> (st_q.dlt == '0));
endmodule

// File: rtl/mdm_ctl_loop.sv
module mdm_ctl_loop
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic             reg_sel_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             ser_tx_i,
    output logic             ser_rx_o,
    output logic             pin_tx_o,
    input  logic             pin_rx_i,
    input  logic             pin_cts_n_i,
    input  logic             pin_dsr_n_i,
    input  logic             pin_ri_n_i,
    input  logic             pin_cd_n_i,
    output logic             pin_dtr_n_o,
    output logic             pin_rts_n_o,
    output logic             pin_op1_n_o,
    output logic             pin_op2_n_o,
    output logic             msi_req_o
);
    mctl_t            ctl;
    logic [MIN_N-1:0] ext_n, sync_n, loop_n, sel_n, lvl_n, dlt;
    logic             ctl_wr, stat_clr;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata_i[REG_W-1:CTL_W];
    assign ctl_wr   = reg_wr_i && (reg_sel_i == SEL_CTRL);
    assign stat_clr = reg_rd_i && (reg_sel_i == SEL_STAT);

    mdm_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (ctl_wr),
        .wdata_i (reg_wdata_i[CTL_W-1:0]),
        .ctl_o   (ctl)
    );

    always_comb begin
        ext_n         = '1;
        ext_n[IX_CTS] = pin_cts_n_i;
        ext_n[IX_DSR] = pin_dsr_n_i;
        ext_n[IX_RI]  = pin_ri_n_i;
        ext_n[IX_CD]  = pin_cd_n_i;
        loop_n         = '1;
        loop_n[IX_CTS] = ~ctl.req_send;
        loop_n[IX_DSR] = ~ctl.term_rdy;
        loop_n[IX_RI]  = ~ctl.aux1;
        loop_n[IX_CD]  = ~ctl.aux2;
    end

    mdm_sync #(.W(MIN_N), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_n),
        .sync_o  (sync_n)
    );

    assign sel_n = ctl.loop_en ? loop_n : sync_n;

    mdm_stat #(.N(MIN_N), .RI_IX(IX_RI)) i_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (sel_n),
        .clr_i (stat_clr),
        .lvl_o (lvl_n),
        .dlt_o (dlt)
    );

    always_comb begin
        pin_tx_o    = ctl.loop_en ? 1'b1 : ser_tx_i;
        ser_rx_o    = ctl.loop_en ? ser_tx_i : pin_rx_i;
        pin_dtr_n_o = ctl.loop_en | ~ctl.term_rdy;
        pin_rts_n_o = ctl.loop_en | ~ctl.req_send;
        pin_op1_n_o = ctl.loop_en | ~ctl.aux1;
        pin_op2_n_o = ctl.loop_en | ~ctl.aux2;
        msi_req_o   = |dlt;
        if (reg_sel_i == SEL_STAT) reg_rdata_o = {~lvl_n, dlt};
        else                       reg_rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl};
    end

    // R4: loop-back isolates every output pin at its inactive level
    p_loop_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.loop_en |-> (pin_tx_o && pin_dtr_n_o && pin_rts_n_o && pin_op1_n_o && pin_op2_n_o));

    // R10: request agrees with the flags seen through the status read path
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == SEL_STAT) |-> (msi_req_o == (|reg_rdata_o[MIN_N-1:0])));
endmodule

// File: tb/test_mdm_ctl_loop.sv
module test_mdm_ctl_loop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ser_tx = 1'b0, ser_rx, pin_tx, pin_rx = 1'b1;
    logic [3:0] pin_n = 4'hF;   // [0]=cts [1]=dsr [2]=ri [3]=cd
    logic       dtr_n, rts_n, op1_n, op2_n, msi;
    int         n_chk = 0, n_bad = 0;
    logic [3:0] prev_n;
    logic [7:0] rd;

    always #2 clk = ~clk;

    mdm_ctl_loop i_mdm_ctl_loop (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ser_tx_i(ser_tx), .ser_rx_o(ser_rx), .pin_tx_o(pin_tx), .pin_rx_i(pin_rx),
        .pin_cts_n_i(pin_n[0]), .pin_dsr_n_i(pin_n[1]),
        .pin_ri_n_i(pin_n[2]), .pin_cd_n_i(pin_n[3]),
        .pin_dtr_n_o(dtr_n), .pin_rts_n_o(rts_n),
        .pin_op1_n_o(op1_n), .pin_op2_n_o(op2_n),
        .msi_req_o(msi)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [3:0] edges(input logic [3:0] nw, input logic [3:0] od);
        logic [3:0] e;
        e = nw ^ od;
        e[2] = nw[2] & ~od[2];
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 pins", {4'h0, op2_n, op1_n, rts_n, dtr_n}, 8'h0F);
        check("R1 msi", {7'h0, msi}, 8'h00);
        rd_reg(1'b0, rd); check("R1 ctrl", rd, 8'h00);
        rd_reg(1'b1, rd); check("R1 status", rd, 8'h00);

        // R3 normal pass-through
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ser_tx = k[0]; pin_rx = k[1];
            #1 check("R3 path", {6'h0, ser_rx, pin_tx}, {6'h0, k[1], k[0]});
        end

        // R2 sweep of control values
        for (int v = 0; v < 32; v++) begin
            logic [7:0] wv;
            wv = 8'(v) & 8'h0F | 8'hE0;   // upper junk bits must not stick
            wr_reg(1'b0, wv);
            check("R2 pins", {4'h0, op2_n, op1_n, rts_n, dtr_n}, {4'h0, ~wv[3:0]});
            rd_reg(1'b0, rd); check("R2 readback", rd, {4'h0, wv[3:0]});
        end
        wr_reg(1'b0, 8'h00);

        // R5/R6/R7/R10 sweep over input patterns
        rd_reg(1'b1, rd);
        prev_n = 4'hF;
        for (int k = 0; k < 48; k++) begin
            logic [3:0] p, e;
            p = 4'((k * 7 + 3) ^ (k >> 2));
            e = edges(p, prev_n);
            @(negedge clk) pin_n = p;
            repeat (4) @(negedge clk);
            check("R10 msi", {7'h0, msi}, {7'h0, |e});
            rd_reg(1'b1, rd);
            check("R5 levels", {4'h0, rd[7:4]}, {4'h0, ~p});
            check("R6/R7 flags", {4'h0, rd[3:0]}, {4'h0, e});
            check("R9 cleared", {7'h0, msi}, 8'h00);
            prev_n = p;
        end

        // R7 explicit: ring 1->0 gives no flag, 0->1 gives flag
        @(negedge clk) pin_n = 4'hF;
        repeat (5) @(negedge clk);
        rd_reg(1'b1, rd);
        @(negedge clk) pin_n = 4'hB;
        repeat (5) @(negedge clk);
        check("R7 falling ring", {7'h0, msi}, 8'h00);
        @(negedge clk) pin_n = 4'hF;
        repeat (5) @(negedge clk);
        rd_reg(1'b1, rd); check("R7 rising ring", rd, 8'h04);

        // R5 latency and R11 stickiness
        @(negedge clk) pin_n = 4'hE;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 latency early", {7'h0, msi}, 8'h00);
        @(negedge clk);
        check("R5 latency on time", {7'h0, msi}, 8'h01);
        repeat (20) @(negedge clk);
        rd_reg(1'b1, rd); check("R11 sticky", rd, 8'h11);

        // R4/R8 loop-back sweep
        prev_n = pin_n;
        for (int v = 0; v < 16; v++) begin
            logic [3:0] a, ln, e;
            a  = {v[3], v[2], v[0], v[1]};
            ln = ~a;
            e  = edges(ln, prev_n);
            wr_reg(1'b0, 8'h10 | 8'(v));
            repeat (2) @(negedge clk);
            check("R4 pins isolated", {3'h0, pin_tx, op2_n, op1_n, rts_n, dtr_n}, 8'h1F);
            @(negedge clk) ser_tx = v[0]; pin_rx = ~v[0];
            #1 check("R4 loop data", {7'h0, ser_rx}, {7'h0, v[0]});
            rd_reg(1'b1, rd);
            check("R8 looped status", rd, {a, e});
            prev_n = ln;
        end

        // R8 external pins ignored in loop-back
        for (int k = 0; k < 6; k++) begin
            @(negedge clk) pin_n = 4'(k * 5);
            repeat (5) @(negedge clk);
            check("R8 ignore msi", {7'h0, msi}, 8'h00);
            rd_reg(1'b1, rd); check("R8 ignore levels", rd, 8'hF0);
        end

        // R9 read and new change on the same edge
        wr_reg(1'b0, 8'h10);
        repeat (3) @(negedge clk);
        rd_reg(1'b1, rd);
        wr_reg(1'b0, 8'h11);
        repeat (3) @(negedge clk);
        wr_reg(1'b0, 8'h13);
        reg_rd = 1'b1; reg_sel = 1'b1;
        #1 check("R9 read data", reg_rdata, 8'h22);
        @(negedge clk) reg_rd = 1'b0;
        #1 check("R9 new flag kept", reg_rdata, 8'h31);
        check("R10 msi after collision", {7'h0, msi}, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule